// File: doc/BRIEF.md
# Rotate and Wraparound Mask Unit

This unit performs the rotate-and-mask step of a 64-bit integer datapath. A 64-bit operand is rotated left by a 6-bit amount, a mask is built from two bounds, and the unit returns the rotated word, the mask and their bitwise AND. Bits are counted from the most significant end: position 0 is the MSB and position 63 is the LSB. The mask is a single contiguous run when the start bound is not above the end bound. When the start bound is above the end bound, the mask wraps around and covers both ends of the word.

A word-size select picks between 64-bit and 32-bit operation. In 32-bit operation the low word of the operand is copied into both halves, and this doubled word is rotated as a 64-bit value. Both mask bounds are taken as offsets inside the low word and are moved up by 32 positions.

The parameter `REG_OUT` chooses how the results leave the unit. With `REG_OUT=0` the outputs are combinational and `out_valid` follows `in_valid`. With `REG_OUT=1` a two-state output stage registers the results. Its state `OS_EMPTY` moves to `OS_FULL` on the transition *load* (`in_valid` high). `OS_FULL` stays in `OS_FULL` on *reload* (`in_valid` high) and returns to `OS_EMPTY` on *drain* (`in_valid` low). `OS_EMPTY` stays in `OS_EMPTY` on *idle*. The output data registers load only on `in_valid`.

Top module: `rwm_unit`

## Requirements
- R1: With `wide`=1, `rot_out` is `src` rotated left by `rot_amt` (0 to 63). Example: 0xDEADBEEF12345678 rotated by 10 gives 0xB6FBBC48D159E37A, and rotated by 35 gives 0x91A2B3C6F56DF778.
- R2: With `wide`=0, `rot_out` is {src[31:0], src[31:0]} rotated left by `rot_amt[4:0]`. `rot_amt[5]` and `src[63:32]` have no effect, and both 32-bit halves of `rot_out` are equal.
- R3: When the effective start bound x is not above the effective end bound y, `mask_out` sets MSB-numbered positions x through y and clears every other position. Position p is vector bit 63-p. Example: x=37, y=63 gives 0x0000000007FFFFFF.
- R4: When x is above y, `mask_out` sets positions x through 63 and positions 0 through y, and clears the positions between them. Example: x=47, y=37 gives 0xFFFFFFFFFC01FFFF.
- R5: When x equals y, `mask_out` has exactly one bit set, at position x. Example: x=0 gives 0x8000000000000000.
- R6: With `wide`=1, x=`mb` and y=`me`. With `wide`=0, x=32+`mb[4:0]` and y=32+`me[4:0]`, and bit 5 of both bounds is ignored. Example: bounds 5 and 15 give 0x0000000007FF0000.
- R7: `res_out` equals `rot_out` AND `mask_out`.
- R8: With `REG_OUT`=1, `out_valid` is 0 while `rst_n` is low. `out_valid` is 1 in the cycle after a clock edge that sees `in_valid` high, and 0 after an edge that sees it low. The data outputs then show the results for the inputs sampled at that edge.
- R9: With `REG_OUT`=1, a clock edge with `in_valid` low leaves `rot_out`, `mask_out` and `res_out` unchanged, even if the inputs change.
- R10: With `REG_OUT`=0, all outputs follow the inputs within the same cycle and `out_valid` equals `in_valid`. The mask and the other results are correct while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Asynchronous active-low reset of the output stage state |
| in_valid | input | 1 | Input operands are valid |
| src | input | 64 | Operand to rotate |
| rot_amt | input | 6 | Left-rotate amount |
| wide | input | 1 | 1 = 64-bit operation, 0 = 32-bit operation |
| mb | input | 6 | Mask start bound (MSB-first position) |
| me | input | 6 | Mask end bound (MSB-first position) |
| out_valid | output | 1 | Results are valid |
| rot_out | output | 64 | Rotated word |
| mask_out | output | 64 | Generated mask |
| res_out | output | 64 | Rotated word AND mask |

## Verification
The bench builds two copies of the unit with `XLEN`=64. The instance `uut` uses `REG_OUT`=1, and the instance `uut_comb` uses `REG_OUT`=0, so both branches of the output generate are elaborated and checked against the same vectors. The registered copy covers the empty/full transitions, holding data while `in_valid` is low, and the reset value of `out_valid`. The combinational copy covers same-cycle results while reset is held low. Together the vectors cover contiguous, wrapped and single-bit masks, the ignored upper bits in 32-bit operation, and rotate amounts of 0 and 63.

// File: rtl/rwm_pkg.sv
package rwm_pkg;

    // State of the optional registered output stage.
    typedef enum logic {
        OS_EMPTY = 1'b0,
        OS_FULL  = 1'b1
    } ostate_e;

endpackage

// File: rtl/rwm_rotate.sv
module rwm_rotate #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0]         src,
    input  logic [$clog2(XLEN)-1:0] amt,
    input  logic                    wide,
    output logic [XLEN-1:0]         rot
);
    localparam int SHW  = $clog2(XLEN);
    localparam int HALF = XLEN / 2;

    logic [XLEN-1:0]   word;
    logic [SHW-1:0]    amt_eff;
    logic [2*XLEN-1:0] dbl;

    always_comb begin
        // Narrow mode copies the low half into both halves and rotates the whole word.
        word    = wide ? src : {src[HALF-1:0], src[HALF-1:0]};
        amt_eff = wide ? amt : {1'b0, amt[SHW-2:0]};
        dbl     = {word, word} << amt_eff;
        rot     = dbl[2*XLEN-1:XLEN];
    end
endmodule

// File: rtl/rwm_mask.sv
module rwm_mask #(
    parameter int XLEN = 64
) (
    input  logic [$clog2(XLEN)-1:0] first,
    input  logic [$clog2(XLEN)-1:0] last,
    input  logic                    wide,
    output logic [XLEN-1:0]         mask
);
    localparam int SHW = $clog2(XLEN);

    logic [SHW-1:0]  x_pos;
    logic [SHW-1:0]  y_pos;
    logic [XLEN-1:0] from_x;  // MSB-first positions >= x
    logic [XLEN-1:0] upto_y;  // MSB-first positions <= y
    logic            wrap;

    always_comb begin
        // Setting the top bound bit adds HALF in narrow mode.
        x_pos  = wide ? first : {1'b1, first[SHW-2:0]};
        y_pos  = wide ? last  : {1'b1, last[SHW-2:0]};
        wrap   = x_pos > y_pos;
        from_x = {XLEN{1'b1}} >> x_pos;
        upto_y = ~(({XLEN{1'b1}} >> y_pos) >> 1);
        mask   = wrap ? (from_x | upto_y) : (from_x & upto_y);
    end
endmodule

// File: rtl/rwm_outstage.sv
module rwm_outstage
    import rwm_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [XLEN-1:0] d_rot,
    input  logic [XLEN-1:0] d_mask,
    input  logic [XLEN-1:0] d_res,
    output logic            out_valid,
    output logic [XLEN-1:0] q_rot,
    output logic [XLEN-1:0] q_mask,
    output logic [XLEN-1:0] q_res
);
    ostate_e state_q;
    ostate_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OS_EMPTY: if (in_valid)  state_d = OS_FULL;   // load
            OS_FULL:  if (!in_valid) state_d = OS_EMPTY;  // drain, else reload
            default:  state_d = OS_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= OS_EMPTY;
        else        state_q <= state_d;
    end

    // Data registers carry no reset; they load only with a valid input.
    always_ff @(posedge clk) begin
        if (in_valid) begin
            q_rot  <= d_rot;
            q_mask <= d_mask;
            q_res  <= d_res;
        end
    end

    always_comb out_valid = (state_q == OS_FULL);
endmodule

// File: rtl/rwm_unit.sv
module rwm_unit #(
    parameter int XLEN    = 64,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [XLEN-1:0]         src,
    input  logic [$clog2(XLEN)-1:0] rot_amt,
    input  logic                    wide,
    input  logic [$clog2(XLEN)-1:0] mb,
    input  logic [$clog2(XLEN)-1:0] me,
    output logic                    out_valid,
    output logic [XLEN-1:0]         rot_out,
    output logic [XLEN-1:0]         mask_out,
    output logic [XLEN-1:0]         res_out
);
    logic [XLEN-1:0] rot_c;
    logic [XLEN-1:0] mask_c;
    logic [XLEN-1:0] res_c;

    rwm_rotate #(.XLEN(XLEN)) u_rot (
        .src  (src),
        .amt  (rot_amt),
        .wide (wide),
        .rot  (rot_c)
    );

    rwm_mask #(.XLEN(XLEN)) u_mask (
        .first (mb),
        .last  (me),
        .wide  (wide),
        .mask  (mask_c)
    );

    always_comb res_c = rot_c & mask_c;

    generate
        if (REG_OUT) begin : g_reg
            rwm_outstage #(.XLEN(XLEN)) u_out (
                .clk       (clk),
                .rst_n     (rst_n),
                .in_valid  (in_valid),
                .d_rot     (rot_c),
                .d_mask    (mask_c),
                .d_res     (res_c),
                .out_valid (out_valid),
                .q_rot     (rot_out),
                .q_mask    (mask_out),
                .q_res     (res_out)
            );
        end else begin : g_comb
            always_comb begin
                out_valid = in_valid;
                rot_out   = rot_c;
                mask_out  = mask_c;
                res_out   = res_c;
            end
        end
    endgenerate
endmodule

// File: rtl/rwm_unit_chk.sv
module rwm_unit_chk #(
    parameter int XLEN    = 64,
    parameter bit REG_OUT = 1'b1
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic                    wide,
    input logic [$clog2(XLEN)-1:0] mb,
    input logic [$clog2(XLEN)-1:0] me,
    input logic                    out_valid,
    input logic [XLEN-1:0]         rot_out,
    input logic [XLEN-1:0]         mask_out,
    input logic [XLEN-1:0]         res_out
);
    localparam int SHW  = $clog2(XLEN);
    localparam int HALF = XLEN / 2;

    logic same_bound;
    always_comb same_bound = wide ? (mb == me) : (mb[SHW-2:0] == me[SHW-2:0]);

    // R7: the result never has a bit outside the mask or the rotated word
    p_res_subset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (((res_out & ~mask_out) == '0) && ((res_out & ~rot_out) == '0)));

    // R3: a mask always covers at least its start position
    p_mask_nonempty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (mask_out != '0));

    generate
        if (REG_OUT) begin : g_reg_chk
            p_valid_next_r8: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> out_valid);
            p_idle_next_r8: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> !out_valid);
            p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> ($stable(rot_out) && $stable(mask_out) && $stable(res_out)));
            p_halves_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && !wide) |=> (rot_out[XLEN-1:HALF] == rot_out[HALF-1:0]));
            p_single_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && same_bound) |=> ($countones(mask_out) == 1));
        end else begin : g_comb_chk
            p_halves_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && !wide) |-> (rot_out[XLEN-1:HALF] == rot_out[HALF-1:0]));
            p_single_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && same_bound) |-> ($countones(mask_out) == 1));
        end
    endgenerate
endmodule

bind rwm_unit rwm_unit_chk #(.XLEN(XLEN), .REG_OUT(REG_OUT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .wide      (wide),
    .mb        (mb),
    .me        (me),
    .out_valid (out_valid),
    .rot_out   (rot_out),
    .mask_out  (mask_out),
    .res_out   (res_out)
);

// File: tb/rwm_unit_test.sv
`timescale 1ns/1ps
module rwm_unit_test;
    typedef struct packed {
        logic        wide;
        logic [5:0]  amt;
        logic [5:0]  mb;
        logic [5:0]  me;
        logic [63:0] src;
        logic [63:0] rot;
        logic [63:0] mask;
        logic [7:0]  tag;   // requirement number of the mask case
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 6'd10, 6'd37, 6'd63, 64'hDEADBEEF12345678, 64'hB6FBBC48D159E37A, 64'h0000000007FFFFFF, 8'd3},
        '{1'b1, 6'd35, 6'd0,  6'd37, 64'hDEADBEEF12345678, 64'h91A2B3C6F56DF778, 64'hFFFFFFFFFC000000, 8'd3},
        '{1'b1, 6'd58, 6'd47, 6'd37, 64'hDEADBEEF12345678, 64'hE37AB6FBBC48D159, 64'hFFFFFFFFFC01FFFF, 8'd4},
        '{1'b1, 6'd22, 6'd0,  6'd0,  64'hDEADBEEF12345678, 64'hBBC48D159E37AB6F, 64'h8000000000000000, 8'd5},
        '{1'b0, 6'd10, 6'd5,  6'd15, 64'h00000000DEADBEEF, 64'hB6FBBF7AB6FBBF7A, 64'h0000000007FF0000, 8'd6},
        '{1'b0, 6'd17, 6'd0,  6'd26, 64'h12345678DEADBEEF, 64'h7DDFBD5B7DDFBD5B, 64'h00000000FFFFFFE0, 8'd6},
        '{1'b0, 6'd57, 6'd30, 6'd2,  64'hFFFFFFFFDEADBEEF, 64'hDFBD5B7DDFBD5B7D, 64'hFFFFFFFFE0000003, 8'd4},
        '{1'b0, 6'd30, 6'd32, 6'd33, 64'h00000000DEADBEEF, 64'hF7AB6FBBF7AB6FBB, 64'h00000000C0000000, 8'd6},
        '{1'b0, 6'd0,  6'd1,  6'd1,  64'hA5A5A5A5DEADBEEF, 64'hDEADBEEFDEADBEEF, 64'h0000000040000000, 8'd5},
        '{1'b1, 6'd0,  6'd10, 6'd63, 64'hDEADBEEF12345678, 64'hDEADBEEF12345678, 64'h003FFFFFFFFFFFFF, 8'd3},
        '{1'b1, 6'd63, 6'd58, 6'd63, 64'hDEADBEEF12345678, 64'h6F56DF77891A2B3C, 64'h000000000000003F, 8'd3},
        '{1'b1, 6'd1,  6'd0,  6'd58, 64'h0000000000000001, 64'h0000000000000002, 64'hFFFFFFFFFFFFFFE0, 8'd3},
        '{1'b1, 6'd1,  6'd32, 6'd32, 64'h8000000000000001, 64'h0000000000000003, 64'h0000000080000000, 8'd5}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] src = 64'h0;
    logic [5:0]  rot_amt = 6'd0;
    logic        wide = 1'b0;
    logic [5:0]  mb = 6'd5;
    logic [5:0]  me = 6'd15;

    logic        ov_r, ov_c;
    logic [63:0] rot_r, mask_r, res_r, rot_c, mask_c, res_c;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    rwm_unit #(.XLEN(64), .REG_OUT(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src(src), .rot_amt(rot_amt),
        .wide(wide), .mb(mb), .me(me), .out_valid(ov_r), .rot_out(rot_r),
        .mask_out(mask_r), .res_out(res_r)
    );

    rwm_unit #(.XLEN(64), .REG_OUT(1'b0)) uut_comb (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src(src), .rot_amt(rot_amt),
        .wide(wide), .mb(mb), .me(me), .out_valid(ov_c), .rot_out(rot_c),
        .mask_out(mask_c), .res_out(res_c)
    );

    task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic string rot_req(input logic w);
        return w ? "R1" : "R2";
    endfunction

    function automatic string mask_req(input logic [7:0] t);
        case (t)
            8'd4:    return "R4";
            8'd5:    return "R5";
            8'd6:    return "R6";
            default: return "R3";
        endcase
    endfunction

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // Reset state: registered valid low, combinational mask live (R8, R10)
        repeat (3) @(negedge clk);
        check("R8", "out_valid in reset", {63'b0, ov_r}, 64'h0);
        check("R10", "mask during reset", mask_c, 64'h0000000007FF0000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8", "out_valid idle", {63'b0, ov_r}, 64'h0);

        for (int i = 0; i < NV; i++) begin
            in_valid = 1'b1;
            wide     = VECS[i].wide;
            rot_amt  = VECS[i].amt;
            mb       = VECS[i].mb;
            me       = VECS[i].me;
            src      = VECS[i].src;
            #1;
            check(rot_req(VECS[i].wide), "comb rot", rot_c, VECS[i].rot);
            check(mask_req(VECS[i].tag), "comb mask", mask_c, VECS[i].mask);
            check("R7", "comb res", res_c, VECS[i].rot & VECS[i].mask);
            check("R10", "comb valid", {63'b0, ov_c}, 64'h1);
            @(negedge clk);
            check("R8", "reg valid", {63'b0, ov_r}, 64'h1);
            check(rot_req(VECS[i].wide), "reg rot", rot_r, VECS[i].rot);
            check(mask_req(VECS[i].tag), "reg mask", mask_r, VECS[i].mask);
            check("R7", "reg res", res_r, VECS[i].rot & VECS[i].mask);
        end

        // Hold: drop valid and change inputs; registered outputs keep the last vector (R9)
        in_valid = 1'b0;
        wide     = 1'b1;
        rot_amt  = 6'd4;
        mb       = 6'd0;
        me       = 6'd63;
        src      = 64'h0123456789ABCDEF;
        #1;
        check("R10", "comb follows", rot_c, 64'h123456789ABCDEF0);
        check("R10", "comb valid low", {63'b0, ov_c}, 64'h0);
        check("R3", "full mask", mask_c, 64'hFFFFFFFFFFFFFFFF);
        @(negedge clk);
        check("R8", "valid drained", {63'b0, ov_r}, 64'h0);
        check("R9", "hold rot", rot_r, VECS[NV-1].rot);
        check("R9", "hold mask", mask_r, VECS[NV-1].mask);
        check("R9", "hold res", res_r, VECS[NV-1].rot & VECS[NV-1].mask);
        @(negedge clk);
        check("R9", "hold rot 2", rot_r, VECS[NV-1].rot);

        // Back-to-back loads then a reset while full (R8)
        in_valid = 1'b1;
        wide     = 1'b0;
        rot_amt  = 6'd32;    // bit 5 ignored in narrow mode
        mb       = 6'd31;
        me       = 6'd0;     // wrap in the low word
        src      = 64'hFFFF0000CAFEF00D;
        @(negedge clk);
        check("R2", "narrow amt 32", rot_r, 64'hCAFEF00DCAFEF00D);
        check("R4", "narrow wrap", mask_r, 64'hFFFFFFFF80000001);
        in_valid = 1'b0;
        rst_n    = 1'b0;
        #1;
        check("R8", "async reset", {63'b0, ov_r}, 64'h0);
        @(negedge clk);
        rst_n = 1'b1;

        finished = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule